// File: doc/BRIEF.md
# Indexed RTC Register Port

This block is the host-facing front end of a real-time clock. A host sees two byte addresses. A write to the even address selects one of 128 byte locations. An access to the odd address reads or writes the selected byte. Fourteen of these locations are clock and control registers. The rest are battery-backed scratch storage, held in an inferred block RAM.

The block applies each register's own access rules. These cover a status bit the host cannot write, two registers that ignore writes, and an interrupt flag register that clears when read. Entering or leaving the hold mode for clock setting has side effects. The block also sends strobes to a separate timekeeping engine, which owns the date arithmetic and the rate divider. That engine reports back through event pulses, update-in-progress set/clear pulses and a narrow write port for refreshing the time bytes.

Host reads return data one cycle after the request. The result appears with a valid pulse.

Top module: `rtc_regport`

## Requirements
- R1: A host write to the even port (port select 0) loads the low IDX_W bits of the data as the current index. A host read of the even port returns 0xFF.
- R2: Odd-port (port select 1) accesses read or write the byte at the current index. Read data appears on `rd_data` with `rd_valid` high in the cycle after the request. Scratch locations return the last value written.
- R3: Host writes to index 12 (flag register) and index 13 (status register) have no effect. Index 13 always reads 0x80.
- R4: Bit 7 of index 10 (update-in-progress) is read-only to the host. A host write replaces bits 6..0 and keeps bit 7. `uip_set` sets bit 7 and `uip_clr` clears it.
- R5: A host write to index 11 with bit 7 (hold mode) set clears the update-in-progress bit and stores bit 4 (update interrupt enable) as 0. While hold mode is 1, `uip_set` has no effect.
- R6: A host write to index 11 with bit 7 = 0 while hold mode was 1 gives a one-cycle `tk_load` pulse in the cycle after the write. Any other write to index 11 gives none.
- R7: A host write to index 0, 2, 4, 6, 7, 8 or 9 while hold mode is 0 gives a one-cycle `tk_load` pulse. The same writes in hold mode store the byte without a pulse. Writes to any other index never pulse.
- R8: `ev_periodic`, `ev_alarm` and `ev_update` set bits 6, 5 and 4 of index 12. Bit 7 of index 12 is also set when the event's enable (index 11 bit 6, 5 or 4 respectively) is 1. `irq` follows index 12 bit 7. A host read of index 12 returns its value and then clears the register, which drops `irq`.
- R9: After reset, index 10 reads 0x26, index 11 reads 0x02, index 12 reads 0x00, index 13 reads 0x80, and `irq` and `tk_load` are 0.
- R10: An event that arrives in the same cycle as a read of index 12 is absent from the returned value and survives in the register after the clear.
- R11: A timekeeper write (`tk_wr_en`) stores its byte only when its index is below 10, hold mode is 0, and no odd-port host write occurs in that cycle.
- R12: `cfg_a` and `cfg_b` show the current contents of index 10 and index 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 1 | 0 = index port, 1 = data port |
| acc_wdata | input | 8 | Host write data |
| rd_data | output | 8 | Read data, valid when rd_valid is 1 |
| rd_valid | output | 1 | Read data strobe, one cycle after the request |
| ev_periodic | input | 1 | Periodic tick event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| uip_set | input | 1 | Raise update-in-progress |
| uip_clr | input | 1 | Drop update-in-progress |
| tk_wr_en | input | 1 | Timekeeper byte write enable |
| tk_wr_idx | input | IDX_W | Timekeeper write index |
| tk_wr_data | input | 8 | Timekeeper write data |
| tk_load | output | 1 | Strobe: reload time from the registers |
| cfg_a | output | 8 | Contents of index 10 |
| cfg_b | output | 8 | Contents of index 11 |
| irq | output | 1 | Interrupt request, index 12 bit 7 |

## Verification
The bench builds the block with the default IDX_W of 7, which gives the full 128-byte space. This makes the top location 127 reachable. It also lets an index byte with bit 7 set (0x8A) show that the extra bit is dropped and the access lands on index 10. Same-cycle collisions are driven deliberately: a flag-register read together with an alarm event, and a host data write together with a timekeeper write.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_CFGA = 10;
  localparam int IDX_CFGB = 11;
  localparam int IDX_FLAG = 12;
  localparam int IDX_STAT = 13;
  localparam int TK_LIMIT = 10;

  localparam logic [7:0] CFGA_RST = 8'h26;
  localparam logic [7:0] CFGB_RST = 8'h02;
  localparam logic [7:0] FLAG_RST = 8'h00;
  localparam logic [7:0] STAT_VAL = 8'h80;

  localparam int A_BUSY  = 7;
  localparam int B_HOLD  = 7;
  localparam int B_PEN   = 6;
  localparam int B_AEN   = 5;
  localparam int B_UEN   = 4;
  localparam int F_ANY   = 7;
  localparam int F_PER   = 6;
  localparam int F_ALM   = 5;
  localparam int F_UPD   = 4;

  // time and date bytes whose host write triggers a reload
  function automatic logic is_time_byte(input int i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 6) ||
           (i == 7) || (i == 8) || (i == 9);
  endfunction

  function automatic logic is_ctrl_byte(input int i);
    return (i >= IDX_CFGA) && (i <= IDX_STAT);
  endfunction
endpackage

// File: rtl/rtc_nvram.sv
module rtc_nvram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, synchronous read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtc_host_decode.sv
module rtc_host_decode
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_port,
  input  logic [7:0]       acc_wdata,
  input  logic             hold_mode,
  output logic [IDX_W-1:0] idx,
  output logic             wr_ram,
  output logic             wr_cfga,
  output logic             wr_cfgb,
  output logic             rd_flag,
  output logic             rd_any,
  output logic             rd_data_port,
  output logic             data_wr,
  output logic             load_req
);
  logic [IDX_W-1:0] idx_q;
  logic             idx_wr;
  logic             data_rd;
  int               cur;

  assign idx_wr  = acc_valid &  acc_write & ~acc_port;
  assign data_wr = acc_valid &  acc_write &  acc_port;
  assign data_rd = acc_valid & ~acc_write &  acc_port;
  assign cur     = int'(idx_q);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= acc_wdata[IDX_W-1:0];
  end

  always_comb begin
    wr_ram       = data_wr & ~is_ctrl_byte(cur);
    wr_cfga      = data_wr & (cur == IDX_CFGA);
    wr_cfgb      = data_wr & (cur == IDX_CFGB);
    rd_flag      = data_rd & (cur == IDX_FLAG);
    rd_any       = acc_valid & ~acc_write;
    rd_data_port = data_rd;
    load_req     = (data_wr & is_time_byte(cur) & ~hold_mode) |
                   (wr_cfgb & ~acc_wdata[B_HOLD] & hold_mode);
  end

  assign idx = idx_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cfga,
  input  logic       wr_cfgb,
  input  logic       rd_flag,
  input  logic [7:0] wdata,
  input  logic       uip_set,
  input  logic       uip_clr,
  input  logic       ev_periodic,
  input  logic       ev_alarm,
  input  logic       ev_update,
  output logic [7:0] cfga,
  output logic [7:0] cfgb,
  output logic [7:0] flags,
  output logic       irq
);
  logic [7:0] a_q, b_q, f_q;
  logic [7:0] a_d, b_d, f_new;
  logic       busy_d;
  logic       any_new;

  always_comb begin
    // host owns bits 6..0, bit 7 is driven only by the update handshake
    a_d = wr_cfga ? {a_q[A_BUSY], wdata[6:0]} : a_q;
    busy_d = a_q[A_BUSY];
    if ((wr_cfgb && wdata[B_HOLD]) || uip_clr) busy_d = 1'b0;
    else if (uip_set && !b_q[B_HOLD])          busy_d = 1'b1;
    a_d[A_BUSY] = busy_d;

    b_d = b_q;
    if (wr_cfgb) begin
      b_d = wdata;
      if (wdata[B_HOLD]) b_d[B_UEN] = 1'b0;
    end

    any_new = (ev_periodic & b_q[B_PEN]) | (ev_alarm & b_q[B_AEN]) |
              (ev_update & b_q[B_UEN]);
    f_new = 8'h00;
    f_new[F_ANY] = any_new;
    f_new[F_PER] = ev_periodic;
    f_new[F_ALM] = ev_alarm;
    f_new[F_UPD] = ev_update;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= CFGA_RST;
      b_q <= CFGB_RST;
      f_q <= FLAG_RST;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      // read-clear and event-set merged: new bits always survive
      f_q <= (rd_flag ? 8'h00 : f_q) | f_new;
    end
  end

  assign cfga  = a_q;
  assign cfgb  = b_q;
  assign flags = f_q;
  assign irq   = f_q[F_ANY];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_port,
  input  logic [7:0]       acc_wdata,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             ev_periodic,
  input  logic             ev_alarm,
  input  logic             ev_update,
  input  logic             uip_set,
  input  logic             uip_clr,
  input  logic             tk_wr_en,
  input  logic [IDX_W-1:0] tk_wr_idx,
  input  logic [7:0]       tk_wr_data,
  output logic             tk_load,
  output logic [7:0]       cfg_a,
  output logic [7:0]       cfg_b,
  output logic             irq
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] cur_idx;
  logic wr_ram, wr_cfga, wr_cfgb, rd_flag, rd_any, rd_data_port, data_wr, load_req;
  logic [7:0] a_v, b_v, f_v;
  logic tk_ok, ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [7:0] ram_wdata, ram_q;
  logic [7:0] hold_q;
  logic src_ram_q, rd_valid_q, load_q;

  rtc_host_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_port(acc_port),
    .acc_wdata(acc_wdata), .hold_mode(b_v[B_HOLD]),
    .idx(cur_idx), .wr_ram(wr_ram), .wr_cfga(wr_cfga), .wr_cfgb(wr_cfgb),
    .rd_flag(rd_flag), .rd_any(rd_any), .rd_data_port(rd_data_port),
    .data_wr(data_wr), .load_req(load_req)
  );

  rtc_ctrl_regs u_regs (
    .clk(clk), .rst(rst),
    .wr_cfga(wr_cfga), .wr_cfgb(wr_cfgb), .rd_flag(rd_flag),
    .wdata(acc_wdata), .uip_set(uip_set), .uip_clr(uip_clr),
    .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
    .cfga(a_v), .cfgb(b_v), .flags(f_v), .irq(irq)
  );

  // timekeeper refresh yields to any host data write in the same cycle
  assign tk_ok     = tk_wr_en & (int'(tk_wr_idx) < TK_LIMIT) &
                     ~b_v[B_HOLD] & ~data_wr;
  assign ram_we    = wr_ram | tk_ok;
  assign ram_waddr = wr_ram ? cur_idx : tk_wr_idx;
  assign ram_wdata = wr_ram ? acc_wdata : tk_wr_data;

  rtc_nvram #(.ADDR_W(IDX_W), .DATA_W(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(cur_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      src_ram_q  <= 1'b0;
      hold_q     <= 8'hFF;
      load_q     <= 1'b0;
    end else begin
      rd_valid_q <= rd_any;
      load_q     <= load_req;
      if (rd_any) begin
        src_ram_q <= rd_data_port & ~is_ctrl_byte(int'(cur_idx));
        if (!rd_data_port) hold_q <= 8'hFF;
        else begin
          case (int'(cur_idx))
            IDX_CFGA: hold_q <= a_v;
            IDX_CFGB: hold_q <= b_v;
            IDX_FLAG: hold_q <= f_v;
            IDX_STAT: hold_q <= STAT_VAL;
            default:  hold_q <= 8'hFF;
          endcase
        end
      end
    end
  end

  assign rd_data  = src_ram_q ? ram_q : hold_q;
  assign rd_valid = rd_valid_q;
  assign tk_load  = load_q;
  assign cfg_a    = a_v;
  assign cfg_b    = b_v;

  initial begin
    if (DEPTH < 16) $error("index space too small for control registers");
  end
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_valid,
  input logic             acc_write,
  input logic             acc_port,
  input logic             wr_hold_bit,
  input logic [IDX_W-1:0] idx,
  input logic             rd_valid,
  input logic [7:0]       rd_data,
  input logic             ev_periodic,
  input logic             ev_alarm,
  input logic             ev_update,
  input logic             tk_load,
  input logic             irq,
  input logic             busy_bit,
  input logic             hold_bit,
  input logic             uen_bit
);
  logic data_wr, data_rd, time_idx, no_ev;
  assign data_wr  = acc_valid & acc_write & acc_port;
  assign data_rd  = acc_valid & ~acc_write & acc_port;
  assign no_ev    = ~ev_periodic & ~ev_alarm & ~ev_update;
  assign time_idx = (idx == IDX_W'(0)) || (idx == IDX_W'(2)) || (idx == IDX_W'(4)) ||
                    (idx == IDX_W'(6)) || (idx == IDX_W'(7)) || (idx == IDX_W'(8)) ||
                    (idx == IDX_W'(9));

  AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(!acc_port)) |-> (rd_data == 8'hFF)); // R1
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write)); // R2
  AST_STATUS_CONST: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(acc_port && idx == IDX_W'(13))) |-> (rd_data == 8'h80)); // R3
  AST_HOLD_FORCES: assert property (@(posedge clk) disable iff (rst)
    (data_wr && idx == IDX_W'(11) && wr_hold_bit) |=> (!busy_bit && !uen_bit && hold_bit)); // R5
  AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    tk_load |-> $past(data_wr)); // R6
  AST_NO_LOAD_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_wr && time_idx && hold_bit) |=> !tk_load); // R7
  AST_FLAG_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (data_rd && idx == IDX_W'(12) && no_ev) |=> !irq); // R8
endmodule

bind rtc_regport rtc_regport_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_port(acc_port), .wr_hold_bit(acc_wdata[7]), .idx(cur_idx),
  .rd_valid(rd_valid), .rd_data(rd_data), .ev_periodic(ev_periodic),
  .ev_alarm(ev_alarm), .ev_update(ev_update), .tk_load(tk_load), .irq(irq),
  .busy_bit(cfg_a[7]), .hold_bit(cfg_b[7]), .uen_bit(cfg_b[4])
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
  localparam int IDX_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_port = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic ev_periodic = 0, ev_alarm = 0, ev_update = 0, uip_set = 0, uip_clr = 0;
  logic tk_wr_en = 0;
  logic [IDX_W-1:0] tk_wr_idx = 0;
  logic [7:0] tk_wr_data = 0;
  logic tk_load, irq;
  logic [7:0] cfg_a, cfg_b;

  int n_chk = 0, n_fail = 0;
  logic last_load;
  logic [7:0] v;

  always #5 clk = ~clk;

  rtc_regport #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .ev_periodic(ev_periodic), .ev_alarm(ev_alarm),
    .ev_update(ev_update), .uip_set(uip_set), .uip_clr(uip_clr),
    .tk_wr_en(tk_wr_en), .tk_wr_idx(tk_wr_idx), .tk_wr_data(tk_wr_data),
    .tk_load(tk_load), .cfg_a(cfg_a), .cfg_b(cfg_b), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_port = port; acc_wdata = d;
    @(negedge clk);
    last_load = tk_load;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic host_rd(input logic port, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_port = port;
    @(negedge clk);
    d = rd_data;
    chk("R2 rd_valid", {7'd0, rd_valid}, 8'h01);
    acc_valid = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    host_wr(1'b0, i);
    host_wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    host_wr(1'b0, i);
    host_rd(1'b1, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_periodic = 1;
      1: ev_alarm = 1;
      2: ev_update = 1;
      3: uip_set = 1;
      default: uip_clr = 1;
    endcase
    @(negedge clk);
    ev_periodic = 0; ev_alarm = 0; ev_update = 0; uip_set = 0; uip_clr = 0;
  endtask

  task automatic tk_write(input logic [IDX_W-1:0] i, input logic [7:0] d);
    @(negedge clk);
    tk_wr_en = 1; tk_wr_idx = i; tk_wr_data = d;
    @(negedge clk);
    tk_wr_en = 0;
  endtask

  task automatic t_reset;
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 tk_load", {7'd0, tk_load}, 8'h00);
    chk("R12 cfg_a", cfg_a, 8'h26);
    reg_rd(8'd10, v); chk("R9 A", v, 8'h26);
    reg_rd(8'd11, v); chk("R9 B", v, 8'h02);
    reg_rd(8'd12, v); chk("R9 C", v, 8'h00);
    reg_rd(8'd13, v); chk("R9 D", v, 8'h80);
  endtask

  task automatic t_index;
    host_rd(1'b0, v); chk("R1 even read", v, 8'hFF);
    host_wr(1'b0, 8'h8A);
    host_rd(1'b1, v); chk("R1 index low bits", v, 8'h26);
  endtask

  task automatic t_nvram;
    reg_wr(8'd14, 8'h5A);
    reg_wr(8'd127, 8'hC3);
    reg_wr(8'd64, 8'h11);
    reg_rd(8'd14, v);  chk("R2 idx14", v, 8'h5A);
    reg_rd(8'd127, v); chk("R2 idx127", v, 8'hC3);
    reg_rd(8'd64, v);  chk("R2 idx64", v, 8'h11);
  endtask

  task automatic t_readonly;
    reg_wr(8'd12, 8'hFF);
    chk("R3 irq after C write", {7'd0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R3 C write ignored", v, 8'h00);
    reg_wr(8'd13, 8'h00);
    reg_rd(8'd13, v); chk("R3 D write ignored", v, 8'h80);
  endtask

  task automatic t_busy;
    pulse(3);
    reg_rd(8'd10, v); chk("R4 busy set", v, 8'hA6);
    reg_wr(8'd10, 8'h00);
    reg_rd(8'd10, v); chk("R4 busy kept on write 0", v, 8'h80);
    pulse(4);
    reg_wr(8'd10, 8'hFF);
    reg_rd(8'd10, v); chk("R4 busy kept on write 1", v, 8'h7F);
    reg_wr(8'd10, 8'h26);
  endtask

  task automatic t_hold;
    pulse(3);
    reg_wr(8'd11, 8'h92);
    chk("R6 no load entering hold", {7'd0, last_load}, 8'h00);
    reg_rd(8'd11, v); chk("R5 UIE forced 0", v, 8'h82);
    chk("R12 cfg_b", cfg_b, 8'h82);
    reg_rd(8'd10, v); chk("R5 busy cleared", v, 8'h26);
    pulse(3);
    reg_rd(8'd10, v); chk("R5 uip_set blocked in hold", v, 8'h26);
  endtask

  task automatic t_load;
    reg_wr(8'd0, 8'h30); chk("R7 no load in hold", {7'd0, last_load}, 8'h00);
    reg_wr(8'd11, 8'h02); chk("R6 load leaving hold", {7'd0, last_load}, 8'h01);
    reg_wr(8'd11, 8'h02); chk("R6 no load without transition", {7'd0, last_load}, 8'h00);
    reg_wr(8'd2, 8'h15); chk("R7 load on minutes write", {7'd0, last_load}, 8'h01);
    reg_wr(8'd9, 8'h24); chk("R7 load on year write", {7'd0, last_load}, 8'h01);
    reg_wr(8'd1, 8'h00); chk("R7 no load on alarm byte", {7'd0, last_load}, 8'h00);
    reg_rd(8'd0, v); chk("R7 hold write stored", v, 8'h30);
  endtask

  task automatic t_irq;
    pulse(0);
    chk("R8 no irq when disabled", {7'd0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R8 periodic flag", v, 8'h40);
    reg_wr(8'd11, 8'h12);
    pulse(2);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);
    reg_rd(8'd12, v); chk("R8 update flags", v, 8'h90);
    chk("R8 irq dropped by read", {7'd0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R8 cleared", v, 8'h00);
  endtask

  task automatic t_merge;
    pulse(2);
    host_wr(1'b0, 8'd12);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_port = 1; ev_alarm = 1;
    @(negedge clk);
    v = rd_data;
    acc_valid = 0; ev_alarm = 0;
    chk("R10 returned value", v, 8'h90);
    chk("R10 irq after merge", {7'd0, irq}, 8'h00);
    reg_rd(8'd12, v); chk("R10 new flag survives", v, 8'h20);
  endtask

  task automatic t_tk;
    tk_write(7'd0, 8'h45);
    reg_rd(8'd0, v); chk("R11 tk write accepted", v, 8'h45);
    reg_wr(8'd11, 8'h82);
    tk_write(7'd0, 8'h59);
    reg_rd(8'd0, v); chk("R11 tk write blocked in hold", v, 8'h45);
    reg_wr(8'd11, 8'h02);
    reg_wr(8'd4, 8'h11);
    host_wr(1'b0, 8'd20);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_port = 1; acc_wdata = 8'h77;
    tk_wr_en = 1; tk_wr_idx = 7'd4; tk_wr_data = 8'h08;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; tk_wr_en = 0;
    reg_rd(8'd20, v); chk("R11 host write wins", v, 8'h77);
    reg_rd(8'd4, v);  chk("R11 tk write dropped on collision", v, 8'h11);
    tk_write(7'd14, 8'h99);
    reg_rd(8'd14, v); chk("R11 tk index limit", v, 8'h5A);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset;
    t_index;
    t_nvram;
    t_readonly;
    t_busy;
    t_hold;
    t_load;
    t_irq;
    t_merge;
    t_tk;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule